// File: doc/BRIEF.md
# Parallel-Load Serializing Shift Register

This block turns a parallel word into a serial bit stream. It runs on a single system clock. Three control pins are brought in as ordinary logic levels: a shift clock, an active-low shift enable and an active-low load. The shift clock and the enable are ORed into one strobe. Every rising edge of that strobe moves the register one stage toward its last stage. The first stage takes a serial input bit.

While the load pin is low, the register keeps copying the parallel inputs on every system clock, and the strobe is ignored. The last stage drives a true output and a complement output. The serial input is fed by a plain register output, so the true output of one instance can drive the serial input of the next instance to form a longer chain.

Because the clock and the enable can be swapped, two pin sequences can fake a strobe edge, and the block records both of them in a sticky error flag. The first is the enable rising while the clock is low. The second is the load being released while the clock and the enable are both low. A synchronous reset clears the register and the flag.

Top module: `piso_serializer`

## Requirements
- R1: A synchronous active-high reset clears every stage to 0 (q=0, q_n=1) and clears proto_err. A strobe level that is already high at the reset is not counted as an edge, so no shift occurs in the first cycle after reset.
- R2: While load_n is low, every stage takes its parallel input bit (stage i from par_in[i]) on each system clock. q then equals par_in[WIDTH-1] and follows it when it changes.
- R3: While load_n is low, rising edges of the strobe have no effect on the stored word.
- R4: While load_n is high, each 0-to-1 change of (shift_clk | shift_en_n) performs exactly one shift toward the last stage. Stage 0 takes ser_in and stage i takes the old stage i-1.
- R5: While shift_en_n is high the strobe stays high, and activity on shift_clk leaves the word unchanged.
- R6: The two strobe pins are interchangeable. With shift_clk held low, a 0-to-1 change of shift_en_n causes one shift.
- R7: q_n is always the inverse of q.
- R8: proto_err is set in two cases: shift_en_n rises while shift_clk is low, or load_n rises while both strobe pins are low. A release of load_n does not itself cause a shift. Once set, proto_err stays set until reset.
- R9: When the q output of one instance drives ser_in of a second instance and both share the control pins, the pair behaves as one register twice as long. The second instance's q shows its own word (MSB first) followed by the first instance's word.
- R10: A strobe that stays high produces only one shift.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| shift_clk | input | 1 | Shift clock pin, sampled as a level |
| shift_en_n | input | 1 | Shift enable pin, active low, sampled as a level |
| load_n | input | 1 | Parallel load pin, active low, level sensitive |
| par_in | input | WIDTH | Parallel data word |
| ser_in | input | 1 | Serial input into stage 0 |
| q | output | 1 | Last stage |
| q_n | output | 1 | Inverse of the last stage |
| proto_err | output | 1 | Sticky flag for illegal strobe and load sequences |

## Verification
The assertions assume that every pin level lasts at least SYNC_DEPTH+1 system clocks, so the synchronizer sees each level and no pulse is lost. They also assume that par_in and ser_in are steady around the cycle in which a load or a shift acts. The stimulus keeps to this: it changes one set of pin levels at a time on the falling clock edge, then waits four clocks before it samples. The illegal enable and load sequences are driven on purpose only in their own directed tests, each of which ends in a reset.

// File: rtl/piso_pkg.sv
`timescale 1ns/1ps
package piso_pkg;

    localparam int unsigned PISO_WIDTH = 8;
    localparam int unsigned SYNC_DEPTH = 2;

    // control pins as seen after sampling
    typedef struct packed {
        logic load_n;
        logic shclk;
        logic shen_n;
    } pin_bundle_t;

    // per-cycle events derived from the sampled pins
    typedef struct packed {
        logic rise;
        logic en_rise_bad;
        logic ld_rise_bad;
    } strobe_evt_t;

    function automatic logic strobe_of(input pin_bundle_t p);
        return p.shclk | p.shen_n;
    endfunction

endpackage

// File: rtl/piso_pin_sync.sv
`timescale 1ns/1ps
module piso_pin_sync
    import piso_pkg::*;
#(
    parameter int unsigned DEPTH = SYNC_DEPTH
) (
    input  logic        clk,
    input  pin_bundle_t pins_async,
    output pin_bundle_t pins_sync
);
    localparam int unsigned LAST = DEPTH - 1;

    pin_bundle_t chain [DEPTH];

    always_ff @(posedge clk) chain[0] <= pins_async;

    generate
        for (genvar i = 1; i < DEPTH; i++) begin : g_flop
            always_ff @(posedge clk) chain[i] <= chain[i-1];
        end
    endgenerate

    assign pins_sync = chain[LAST];
endmodule

// File: rtl/piso_strobe_detect.sv
`timescale 1ns/1ps
module piso_strobe_detect
    import piso_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_bundle_t pins,
    output strobe_evt_t evt,
    output logic        err_flag
);
    pin_bundle_t hist;
    logic        strobe_now;
    logic        strobe_old;

    assign strobe_now = strobe_of(pins);
    assign strobe_old = strobe_of(hist);

    // The history always tracks the current sampled level. Under reset this
    // seeds it, so a strobe already high is not seen as an edge afterwards.
    always_ff @(posedge clk) hist <= pins;

    always_comb begin
        evt.rise        = strobe_now & ~strobe_old & ~rst;
        evt.en_rise_bad = ~hist.shen_n & pins.shen_n & ~pins.shclk;
        evt.ld_rise_bad = ~hist.load_n & pins.load_n & ~pins.shclk & ~pins.shen_n;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            err_flag <= 1'b0;
        end else if (evt.en_rise_bad || evt.ld_rise_bad) begin
            err_flag <= 1'b1;
        end
    end
endmodule

// File: rtl/piso_stage_chain.sv
`timescale 1ns/1ps
module piso_stage_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_act,
    input  logic             shift,
    input  logic             ser_in,
    input  logic [WIDTH-1:0] par_in,
    output logic [WIDTH-1:0] stages
);
    logic [WIDTH-1:0] nxt;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_stage
            logic upstream;
            if (i == 0) begin : g_head
                assign upstream = ser_in;
            end else begin : g_body
                assign upstream = stages[i-1];
            end
            // load has priority over shift
            assign nxt[i] = load_act ? par_in[i] :
                            shift    ? upstream  : stages[i];
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) stages <= '0;
        else     stages <= nxt;
    end
endmodule

// File: rtl/piso_serializer.sv
`timescale 1ns/1ps
module piso_serializer
    import piso_pkg::*;
#(
    parameter int unsigned WIDTH = PISO_WIDTH,
    parameter int unsigned SYNC  = SYNC_DEPTH
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             shift_clk,
    input  logic             shift_en_n,
    input  logic             load_n,
    input  logic [WIDTH-1:0] par_in,
    input  logic             ser_in,
    output logic             q,
    output logic             q_n,
    output logic             proto_err
);
    localparam int unsigned MSB = WIDTH - 1;

    pin_bundle_t      pins_raw;
    pin_bundle_t      pins_s;
    strobe_evt_t      evt;
    logic             ld_act;
    logic [WIDTH-1:0] stage_q;

    assign pins_raw = '{load_n: load_n, shclk: shift_clk, shen_n: shift_en_n};

    piso_pin_sync #(.DEPTH(SYNC)) u_sync (
        .clk        (clk),
        .pins_async (pins_raw),
        .pins_sync  (pins_s)
    );

    piso_strobe_detect u_detect (
        .clk      (clk),
        .rst      (rst),
        .pins     (pins_s),
        .evt      (evt),
        .err_flag (proto_err)
    );

    assign ld_act = ~pins_s.load_n;

    piso_stage_chain #(.WIDTH(WIDTH)) u_chain (
        .clk      (clk),
        .rst      (rst),
        .load_act (ld_act),
        .shift    (evt.rise),
        .ser_in   (ser_in),
        .par_in   (par_in),
        .stages   (stage_q)
    );

    assign q   = stage_q[MSB];
    assign q_n = ~stage_q[MSB];
endmodule

// File: rtl/piso_serializer_chk.sv
`timescale 1ns/1ps
module piso_serializer_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             ld_act,
    input logic             shift_pulse,
    input logic             ser_in,
    input logic [WIDTH-1:0] par_in,
    input logic [WIDTH-1:0] stages,
    input logic             proto_err
);
    AST_RESET_CLEARS: assert property (@(posedge clk)
        $past(rst) |-> (stages == '0 && !proto_err)); // R1

    AST_NO_EDGE_AFTER_RESET: assert property (@(posedge clk)
        $past(rst) |-> !shift_pulse); // R1

    AST_LOAD_CAPTURE: assert property (@(posedge clk) disable iff (rst)
        ld_act |=> stages == $past(par_in)); // R2

    AST_SHIFT_STEP: assert property (@(posedge clk) disable iff (rst)
        (!ld_act && shift_pulse) |=>
            stages == {$past(stages[WIDTH-2:0]), $past(ser_in)}); // R4

    AST_HOLD_WORD: assert property (@(posedge clk) disable iff (rst)
        (!ld_act && !shift_pulse) |=> $stable(stages)); // R5

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        proto_err |=> proto_err); // R8

    AST_SINGLE_SHIFT: assert property (@(posedge clk) disable iff (rst)
        shift_pulse |=> !shift_pulse); // R10
endmodule

bind piso_serializer piso_serializer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .ld_act      (ld_act),
    .shift_pulse (evt.rise),
    .ser_in      (ser_in),
    .par_in      (par_in),
    .stages      (stage_q),
    .proto_err   (proto_err)
);

// File: tb/test_piso_serializer.sv
`timescale 1ns/1ps
module test_piso_serializer;
    localparam int W  = 8;
    localparam int NV = 19;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         sclk = 1'b0;
    logic         sen_n = 1'b0;
    logic         ld_n = 1'b1;
    logic [W-1:0] par_h = '0;
    logic [W-1:0] par_t = '0;
    logic         si = 1'b0;
    logic         q_h, qn_h, err_h;
    logic         q_t, qn_t, err_t;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    piso_serializer i_piso_serializer (
        .clk(clk), .rst(rst), .shift_clk(sclk), .shift_en_n(sen_n),
        .load_n(ld_n), .par_in(par_h), .ser_in(si),
        .q(q_h), .q_n(qn_h), .proto_err(err_h)
    );

    piso_serializer i_piso_serializer_tail (
        .clk(clk), .rst(rst), .shift_clk(sclk), .shift_en_n(sen_n),
        .load_n(ld_n), .par_in(par_t), .ser_in(q_h),
        .q(q_t), .q_n(qn_t), .proto_err(err_t)
    );

    // {load_n, shift_clk, shift_en_n, ser_in, par[7:0], expected q}
    localparam logic [12:0] VEC [NV] = '{
        {1'b0,1'b0,1'b0,1'b0,8'hA5,1'b1},  // R2 load A5
        {1'b0,1'b1,1'b0,1'b0,8'hA5,1'b1},  // R3 edge during load
        {1'b0,1'b1,1'b0,1'b0,8'h3C,1'b0},  // R2 follows new word
        {1'b1,1'b1,1'b0,1'b0,8'h3C,1'b0},  // legal release, no shift
        {1'b1,1'b0,1'b0,1'b0,8'h3C,1'b0},
        {1'b1,1'b1,1'b0,1'b1,8'h3C,1'b0},  // R4 -> 79
        {1'b1,1'b0,1'b0,1'b1,8'h3C,1'b0},
        {1'b1,1'b1,1'b0,1'b0,8'h3C,1'b1},  // R4 -> F2
        {1'b1,1'b1,1'b1,1'b0,8'h3C,1'b1},  // enable off while clock high
        {1'b1,1'b0,1'b1,1'b0,8'h3C,1'b1},  // R5
        {1'b1,1'b1,1'b1,1'b0,8'h3C,1'b1},  // R5 no shift
        {1'b1,1'b0,1'b0,1'b0,8'h3C,1'b1},
        {1'b1,1'b1,1'b0,1'b0,8'h3C,1'b1},  // -> E4
        {1'b1,1'b0,1'b0,1'b0,8'h3C,1'b1},
        {1'b1,1'b1,1'b0,1'b0,8'h3C,1'b1},  // -> C8
        {1'b1,1'b0,1'b0,1'b0,8'h3C,1'b1},
        {1'b1,1'b1,1'b0,1'b0,8'h3C,1'b1},  // -> 90
        {1'b1,1'b0,1'b0,1'b0,8'h3C,1'b1},
        {1'b1,1'b1,1'b0,1'b0,8'h3C,1'b0}   // -> 20
    };

    task automatic chk(input logic got, input logic exp, input string tag);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0b expected %0b", tag, got, exp);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic drive(input logic l, input logic c, input logic e, input logic s);
        @(negedge clk);
        ld_n = l; sclk = c; sen_n = e; si = s;
        settle();
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        settle();
    endtask

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            report();
        end
    end

    initial begin
        // R1: reset with strobe already high and ser_in high
        sclk = 1'b1; si = 1'b1; ld_n = 1'b1; sen_n = 1'b0;
        do_reset();
        chk(q_h, 1'b0, "R1 q after reset");
        chk(qn_h, 1'b1, "R1 q_n after reset");
        chk(err_h, 1'b0, "R1 proto_err after reset");
        si = 1'b0;
        for (int k = 0; k < W - 1; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b0);
            drive(1'b1, 1'b1, 1'b0, 1'b0);
        end
        chk(q_h, 1'b0, "R1 no spurious shift after reset");

        // table walk: R2 R3 R4 R5 R7
        sclk = 1'b0;
        do_reset();
        for (int v = 0; v < NV; v++) begin
            @(negedge clk);
            ld_n  = VEC[v][12];
            sclk  = VEC[v][11];
            sen_n = VEC[v][10];
            si    = VEC[v][9];
            par_h = VEC[v][8:1];
            settle();
            chk(q_h, VEC[v][0], $sformatf("R2 R3 R4 R5 vector %0d q", v));
            chk(qn_h, ~VEC[v][0], $sformatf("R7 vector %0d q_n", v));
            chk(err_h, 1'b0, $sformatf("R8 vector %0d no error", v));
        end

        // R10: strobe held high for a long time shifts once only
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        par_h = 8'h00;
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        par_h = 8'h60;
        settle();
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        repeat (20) @(negedge clk);
        chk(q_h, 1'b1, "R10 one shift of 60");
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        chk(q_h, 1'b1, "R10 second shift of 60");

        // R9: cascade of head and tail
        par_h = 8'hC3; par_t = 8'h5A;
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        chk(q_t, 1'b0, "R9 tail MSB before shifting");
        for (int k = 1; k < 2 * W; k++) begin
            drive(1'b1, 1'b0, 1'b0, 1'b0);
            drive(1'b1, 1'b1, 1'b0, 1'b0);
            chk(q_t, logic'(16'h5AC3 >> (2 * W - 1 - k)),
                $sformatf("R9 chained bit after %0d shifts", k));
        end

        // R8: load released with both strobe pins low
        do_reset();
        par_h = 8'h80;
        drive(1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        chk(err_h, 1'b1, "R8 load release while strobe low");
        chk(q_h, 1'b1, "R8 release causes no shift");
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        chk(q_h, 1'b0, "R4 shift after release");
        chk(err_h, 1'b1, "R8 flag sticky");
        do_reset();
        chk(err_h, 1'b0, "R1 reset clears flag");

        // R6: enable used as the shift clock while clock pin stays low
        par_h = 8'h40;
        drive(1'b0, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b1, 1'b0, 1'b0);
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        chk(err_h, 1'b0, "R8 legal sequence leaves flag clear");
        drive(1'b1, 1'b0, 1'b1, 1'b0);
        chk(q_h, 1'b1, "R6 enable edge shifts");
        chk(err_h, 1'b1, "R8 enable rise with clock low");
        drive(1'b1, 1'b0, 1'b0, 1'b0);
        chk(q_h, 1'b1, "R6 enable fall holds");

        done = 1'b1;
        report();
    end
endmodule